// File: doc/BRIEF.md
# Sliding-Window Back-Reference Decoder

This block expands a stream of back-reference codewords into a stream of data symbols. Each codeword holds three fields. The first is a distance that points back into the symbols already produced. The second is a copy count. The third is one literal symbol that closes the codeword. The decoder first copies the requested number of symbols out of its history window, one at a time. It then emits the literal. Every symbol it produces, copied or literal, enters the history window at once. A copy may therefore run past its own starting point and repeat a short pattern many times.

Codewords arrive on a valid/ready port and symbols leave on a second valid/ready port. The window is a shift register of recent symbols. The distance field selects one of its taps, and a down counter loaded with the copy count decides when the literal takes over. The decoder holds one codeword at a time. While that codeword is being expanded, the input port stays closed.

Top module: `lzd_decomp`

## Requirements
- R1: After reset `cw_ready` is 1 and `sym_valid` is 0. Once the literal of a codeword has been transferred, `cw_ready` returns to 1 on the next cycle.
- R2: A copied symbol equals the symbol emitted `cw_ptr` positions earlier. Distance 1 means the most recently emitted symbol.
- R3: A codeword with copy count L yields exactly L copied symbols followed by the literal `cw_lit`, so L+1 symbols in total.
- R4: A codeword with copy count 0 yields exactly one symbol, its literal.
- R5: A copy count larger than the distance is legal. Each copied symbol enters the window before the next copy reads it, so a distance-2, count-12 codeword repeats the last two symbols six times.
- R6: While `sym_valid` is 1 and `sym_ready` is 0, `sym_valid` stays 1 and `sym_data` holds its value on the next cycle.
- R7: Reset clears the window to zero. A distance that reaches past the symbols emitted since reset reads 0.
- R8: From acceptance to the end of a codeword, `sym_valid` is 1 on every cycle. With `sym_ready` held at 1, a count-L codeword finishes in exactly L+1 cycles after its acceptance edge.
- R9: `cw_ready` and `sym_valid` are never 1 together, so no codeword is taken before the previous literal has been transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cw_valid | input | 1 | Codeword present |
| cw_ready | output | 1 | Decoder idle and able to take a codeword |
| cw_ptr | input | PTR_W (5) | Back distance, 1 = newest symbol |
| cw_len | input | LEN_W (8) | Number of symbols to copy |
| cw_lit | input | SYM_W (8) | Literal emitted after the copies |
| sym_valid | output | 1 | Output symbol present |
| sym_ready | input | 1 | Consumer accepts the symbol |
| sym_data | output | SYM_W (8) | Output symbol |

## Verification
On every cycle the bound checker enforces the handshake-level rules. It checks that output is held stable under backpressure and that the input and output ports are never open together. It also tracks how many symbols the current codeword still owes, which gives the gap-free output, the exact count, and a literal that lands in the last slot. Whether each copied symbol has the right value cannot be expressed at the ports without a model of the history. Only the bench scenarios show this, by comparing against a reference history across overlapping copies, the deepest distance, runs of a single symbol and a window cleared by reset.

// File: rtl/lzd_pkg.sv
package lzd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_COPY = 2'd1,
    ST_LIT  = 2'd2
  } lzd_state_e;
endpackage

// File: rtl/lzd_window.sv
module lzd_window #(
  parameter int SYM_W = 8,
  parameter int DEPTH = 16,
  parameter int PTR_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic [SYM_W-1:0] shift_in,
  input  logic [PTR_W-1:0] rd_dist,
  output logic [SYM_W-1:0] rd_data
);
  logic [SYM_W-1:0] tap_q [DEPTH];

  // tap 0 is the newest symbol; each shift moves everything one tap older
  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_tap
      logic [SYM_W-1:0] tap_d;
      if (g == 0) begin : g_head
        assign tap_d = shift_in;
      end else begin : g_body
        assign tap_d = tap_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          tap_q[g] <= '0;
        end else if (shift_en) begin
          tap_q[g] <= tap_d;
        end
      end
    end
  endgenerate

  // distance d selects tap d-1; zero or out-of-range distances read zero
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_dist == PTR_W'(i + 1)) begin
        rd_data = tap_q[i];
      end
    end
  end
endmodule

// File: rtl/lzd_ctrl.sv
module lzd_ctrl
  import lzd_pkg::*;
#(
  parameter int SYM_W = 8,
  parameter int PTR_W = 5,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cw_valid,
  input  logic [PTR_W-1:0] cw_ptr,
  input  logic [LEN_W-1:0] cw_len,
  input  logic [SYM_W-1:0] cw_lit,
  input  logic             sym_ready,
  output logic             cw_ready,
  output logic             sym_valid,
  output logic             sel_lit,
  output logic             xfer,
  output logic [PTR_W-1:0] ptr_q,
  output logic [SYM_W-1:0] lit_q
);
  lzd_state_e       state_q, state_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             load_en, cnt_en;

  assign cw_ready  = (state_q == ST_IDLE);
  assign sym_valid = (state_q != ST_IDLE);
  assign sel_lit   = (state_q == ST_LIT);
  assign xfer      = sym_valid && sym_ready;
  assign load_en   = cw_ready && cw_valid;
  assign cnt_en    = load_en || (xfer && (state_q == ST_COPY));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = cw_len;
        if (cw_valid) begin
          state_d = (cw_len == '0) ? ST_LIT : ST_COPY;
        end
      end
      ST_COPY: begin
        cnt_d = cnt_q - 1'b1;
        if (xfer && (cnt_q == LEN_W'(1))) begin
          state_d = ST_LIT;
        end
      end
      ST_LIT: begin
        if (xfer) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      lit_q <= '0;
    end else if (load_en) begin
      ptr_q <= cw_ptr;
      lit_q <= cw_lit;
    end
  end
endmodule

// File: rtl/lzd_decomp.sv
module lzd_decomp #(
  parameter int SYM_W = 8,
  parameter int DEPTH = 16,
  parameter int LEN_W = 8,
  localparam int PTR_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cw_valid,
  output logic             cw_ready,
  input  logic [PTR_W-1:0] cw_ptr,
  input  logic [LEN_W-1:0] cw_len,
  input  logic [SYM_W-1:0] cw_lit,
  output logic             sym_valid,
  input  logic             sym_ready,
  output logic [SYM_W-1:0] sym_data
);
  logic             rst_meta_q, rst_sync_n;
  logic             sel_lit, xfer;
  logic [PTR_W-1:0] ptr_q;
  logic [SYM_W-1:0] lit_q, win_rd;

  // assert asynchronously, release on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  lzd_ctrl #(.SYM_W(SYM_W), .PTR_W(PTR_W), .LEN_W(LEN_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cw_valid (cw_valid),
    .cw_ptr   (cw_ptr),
    .cw_len   (cw_len),
    .cw_lit   (cw_lit),
    .sym_ready(sym_ready),
    .cw_ready (cw_ready),
    .sym_valid(sym_valid),
    .sel_lit  (sel_lit),
    .xfer     (xfer),
    .ptr_q    (ptr_q),
    .lit_q    (lit_q)
  );

  lzd_window #(.SYM_W(SYM_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_win (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .shift_en(xfer),
    .shift_in(sym_data),
    .rd_dist (ptr_q),
    .rd_data (win_rd)
  );

  assign sym_data = sel_lit ? lit_q : win_rd;
endmodule

// File: rtl/lzd_chk.sv
module lzd_chk #(
  parameter int SYM_W = 8,
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cw_valid,
  input logic             cw_ready,
  input logic [LEN_W-1:0] cw_len,
  input logic [SYM_W-1:0] cw_lit,
  input logic             sym_valid,
  input logic             sym_ready,
  input logic [SYM_W-1:0] sym_data
);
  logic [LEN_W:0]   owed_q;
  logic [SYM_W-1:0] lit_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed_q     <= '0;
      lit_seen_q <= '0;
    end else if (cw_valid && cw_ready) begin
      owed_q     <= {1'b0, cw_len} + 1'b1;
      lit_seen_q <= cw_lit;
    end else if (sym_valid && sym_ready && (owed_q != '0)) begin
      owed_q <= owed_q - 1'b1;
    end
  end

  // R9
  port_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cw_ready && sym_valid));

  // R6
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && !sym_ready) |=> (sym_valid && $stable(sym_data)));

  // R8
  no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owed_q != '0) |-> sym_valid);

  // R3
  no_extra_sym_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> (owed_q != '0));

  // R1
  idle_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owed_q == '0) |-> cw_ready);

  // R4
  literal_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_ready && (owed_q == (LEN_W+1)'(1))) |-> (sym_data == lit_seen_q));
endmodule

bind lzd_decomp lzd_chk #(.SYM_W(SYM_W), .LEN_W(LEN_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cw_valid (cw_valid),
  .cw_ready (cw_ready),
  .cw_len   (cw_len),
  .cw_lit   (cw_lit),
  .sym_valid(sym_valid),
  .sym_ready(sym_ready),
  .sym_data (sym_data)
);

// File: tb/sim_lzd_decomp.sv
`timescale 1ns/1ps
module sim_lzd_decomp;
  localparam int SYM_W = 8;
  localparam int DEPTH = 16;
  localparam int LEN_W = 8;
  localparam int PTR_W = $clog2(DEPTH) + 1;
  localparam int NVEC  = 12;

  // {mode, ptr, len, lit}; mode 1 = throttled consumer
  localparam logic [21:0] VEC [NVEC] = '{
    {1'b0, 5'd1,  8'd0,  8'h43},
    {1'b0, 5'd1,  8'd0,  8'h42},
    {1'b1, 5'd1,  8'd0,  8'h41},
    {1'b0, 5'd1,  8'd0,  8'h44},
    {1'b0, 5'd2,  8'd1,  8'h46},
    {1'b0, 5'd2,  8'd12, 8'h44},
    {1'b1, 5'd16, 8'd3,  8'h10},
    {1'b0, 5'd5,  8'd5,  8'h55},
    {1'b1, 5'd1,  8'd7,  8'h77},
    {1'b0, 5'd3,  8'd0,  8'h99},
    {1'b1, 5'd9,  8'd20, 8'hAA},
    {1'b0, 5'd16, 8'd16, 8'h01}
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cw_valid, cw_ready, sym_valid, sym_ready;
  logic [PTR_W-1:0] cw_ptr;
  logic [LEN_W-1:0] cw_len;
  logic [SYM_W-1:0] cw_lit, sym_data;

  int checks = 0;
  int errors = 0;
  logic [SYM_W-1:0] hist [0:1023];
  int nhist = 0;

  always #5 clk = ~clk;

  lzd_decomp #(.SYM_W(SYM_W), .DEPTH(DEPTH), .LEN_W(LEN_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cw_valid(cw_valid), .cw_ready(cw_ready),
    .cw_ptr(cw_ptr), .cw_len(cw_len), .cw_lit(cw_lit),
    .sym_valid(sym_valid), .sym_ready(sym_ready), .sym_data(sym_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [SYM_W-1:0] model_rd(input int d);
    return (nhist - d >= 0) ? hist[nhist - d] : '0;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cw_valid = 1'b0; sym_ready = 1'b0;
    cw_ptr = '0; cw_len = '0; cw_lit = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    nhist = 0;
    #1;
    chk(cw_ready === 1'b1, "R1 cw_ready after reset", cw_ready, 1);
    chk(sym_valid === 1'b0, "R1 sym_valid after reset", sym_valid, 0);
  endtask

  task automatic run_cw(input int p, input int l, input logic [SYM_W-1:0] lit,
                        input bit throttle, input string ovr);
    int got = 0;
    int cyc = 0;
    bit stall = 0;
    bit excl_ok = 1;
    logic [SYM_W-1:0] held = '0;
    logic [SYM_W-1:0] expv;
    string tag;
    @(negedge clk);
    cw_ptr = PTR_W'(p); cw_len = LEN_W'(l); cw_lit = lit;
    cw_valid = 1'b1; sym_ready = 1'b0;
    #1;
    while (!cw_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    while (got <= l) begin
      @(negedge clk);
      cyc++;
      sym_ready = throttle ? ((cyc % 3) != 1) : 1'b1;
      #1;
      if (cw_ready) excl_ok = 0;
      if (stall) begin
        chk(sym_valid && (sym_data == held), "R6 held under stall", sym_data, held);
      end
      if (sym_valid && sym_ready) begin
        if (got < l) begin
          expv = model_rd(p);
          tag = (ovr != "") ? ovr : ((l > p) ? "R5 overlapped copy" : "R2 copied symbol");
        end else begin
          expv = lit;
          tag = (ovr != "") ? ovr : ((l == 0) ? "R4 literal only" : "R3 closing literal");
        end
        chk(sym_data === expv, tag, sym_data, expv);
        hist[nhist] = expv;
        nhist++;
        got++;
        stall = 0;
      end else begin
        stall = sym_valid;
        held = sym_data;
      end
    end
    @(negedge clk);
    cw_valid = 1'b0; sym_ready = 1'b0;
    #1;
    chk(cw_ready === 1'b1, "R1 ready after literal", cw_ready, 1);
    chk(excl_ok, "R9 input closed while busy", excl_ok, 1);
    if (!throttle) chk(cyc == l + 1, "R8 cycles per codeword", cyc, l + 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    do_reset();
    for (int i = 0; i < NVEC; i++) begin
      run_cw(int'(VEC[i][20:16]), int'(VEC[i][15:8]), VEC[i][7:0], VEC[i][21], "");
    end
    // R7: reset mid-stream, window must read back zero
    do_reset();
    run_cw(3, 2, 8'h5A, 1'b0, "R7 window cleared");
    // R7: distance beyond the history so far reads zero
    run_cw(4, 1, 8'h6B, 1'b0, "R7 beyond history");
    // R5: classic two-symbol pattern repeated
    run_cw(1, 0, 8'h42, 1'b0, "");
    run_cw(2, 12, 8'h44, 1'b1, "");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule